// File: doc/BRIEF.md
# Serial Byte Master with Fill Byte

This block drives a four-wire style serial bus as the clock master and moves one burst of bytes per start strobe. The transmit side fetches bytes from a memory-style read port indexed from zero; the receive side stores each received byte through a memory-style write port, also indexed from zero. The two byte counts are given independently when the burst starts, and the burst lasts for whichever count is larger.

When the transmit count runs out before the receive count, each further byte slot shifts out a programmable fill byte. When the receive count runs out first, the remaining received bytes are thrown away. A zero transmit count therefore makes a read burst that only sends fill bytes, and a zero receive count makes a write burst that stores nothing. A burst with both counts zero produces no clock edges but still reports completion.

Clock polarity, clock phase, the clock divider and the fill byte sit in a small configuration register written through a write strobe; they are captured at the start strobe, so later writes only affect the next burst.

Top module: `spi_fill_master`

## Requirements
- R1: A start strobe seen while idle makes `started_o` high for exactly the next cycle and raises `busy_o`; a start strobe seen while busy produces no started pulse and does not alter the running burst.
- R2: A burst moves max(tx count, rx count) bytes of 8 bits, i.e. 16 SCK transitions per byte, and ends with `end_o` high for exactly one cycle, in which `busy_o` is already low.
- R3: `cfg_mode_i` bit 1 is the clock polarity and bit 0 the clock phase (mode 0: 0/0, 1: 0/1, 2: 1/0, 3: 1/1). Bits go out MSB first. With phase 0, MOSI shows bit 7 before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges; with phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: While idle, SCK and MOSI both sit at the configured polarity level.
- R5: Each SCK half period lasts DIV+1 system clocks, so one byte slot takes one load cycle plus 16×(DIV+1) cycles; mode, divider and fill byte are captured at the start strobe.
- R6: Slot i with i < tx count reads transmit index i (one `tx_rd_o` pulse) and sends that byte; slots with i ≥ tx count send the fill byte and make no read.
- R7: The fill byte register resets to 0x00.
- R8: Received byte i with i < rx count is written once to index i; later received bytes are dropped; `rx_cnt_o` ends at the number of bytes stored.
- R9: With both counts zero, the burst shows no SCK transition, and started and end pulses still occur.
- R10: A zero tx count gives a burst with no transmit reads; a zero rx count gives a burst with no receive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Writes mode, divider and fill byte |
| cfg_mode_i | input | 2 | Bit 1 polarity, bit 0 phase |
| cfg_div_i | input | 8 | Half-period divider DIV |
| cfg_fill_i | input | 8 | Fill byte sent after the transmit data |
| start_i | input | 1 | Start strobe |
| tx_len_i | input | 8 | Transmit byte count, taken at start |
| rx_len_i | input | 8 | Receive byte count, taken at start |
| started_o | output | 1 | One-cycle burst accepted event |
| end_o | output | 1 | One-cycle burst complete event |
| busy_o | output | 1 | Burst in progress |
| tx_rd_o | output | 1 | Transmit byte read strobe |
| tx_idx_o | output | 8 | Transmit byte index |
| tx_data_i | input | 8 | Transmit byte, valid in the cycle of the read |
| rx_wr_o | output | 1 | Receive byte write strobe |
| rx_idx_o | output | 8 | Receive byte index |
| rx_data_o | output | 8 | Received byte |
| rx_cnt_o | output | 8 | Bytes stored in the current or last burst |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Bursts are run with the transmit count below, above and equal to the receive count, with either count zero and with both zero, so that fill slots, dropped receive bytes and the empty burst are each told apart from ordinary traffic. All four modes are used with dividers 0 to 2, and MISO follows a pseudo-random stream, so a wrong sampling edge or bit order changes the stored bytes. A configuration write during a burst and a second start strobe during a burst separate capture-at-start from live use of the inputs.

// File: rtl/spi_fill_pkg.sv
package spi_fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } clk_mode_t;

  function automatic clk_mode_t decode_mode(input logic [1:0] code);
    clk_mode_t m;
    m.cpol = code[1];
    m.cpha = code[0];
    return m;
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // ticks are spaced by DIV+1 cycles, so back-to-back ticks need DIV of zero
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_i && div_i != '0) |=> !tick_o) else $error("tick spacing"); // R5

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_i,
  input  logic              preset_lvl_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              last_edge_o
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic [EW-1:0]     edge_q, edge_d;
  logic [DATA_W-1:0] tx_sh_q, tx_sh_d;
  logic [DATA_W-1:0] rx_sh_q, rx_sh_d;
  logic              sck_q, sck_d;
  logic              mosi_q, mosi_d;
  logic              leading;
  logic              sample_now;
  logic              drive_now;

  assign leading     = !edge_q[0];
  assign sample_now  = tick_i && (cpha_i ? !leading : leading);
  assign drive_now   = tick_i && (cpha_i ? leading : (!leading && edge_q != LAST_EDGE));
  assign last_edge_o = tick_i && (edge_q == LAST_EDGE);

  always_comb begin
    edge_d  = edge_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    sck_d   = sck_q;
    mosi_d  = mosi_q;
    if (preset_i) begin
      sck_d  = preset_lvl_i;
      mosi_d = preset_lvl_i;
    end else if (load_i) begin
      edge_d  = '0;
      tx_sh_d = load_data_i;
      sck_d   = cpol_i;
      if (!cpha_i) begin
        mosi_d = load_data_i[DATA_W-1];
      end
    end else if (tick_i) begin
      edge_d = edge_q + 1'b1;
      sck_d  = !sck_q;
      if (sample_now) begin
        rx_sh_d = {rx_sh_q[DATA_W-2:0], miso_i};
      end
      if (drive_now) begin
        tx_sh_d = {tx_sh_q[DATA_W-2:0], 1'b0};
        mosi_d  = cpha_i ? tx_sh_q[DATA_W-1] : tx_sh_q[DATA_W-2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
    end else begin
      edge_q  <= edge_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      sck_q   <= sck_d;
      mosi_q  <= mosi_d;
    end
  end

  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;
  assign rx_byte_o = rx_sh_q;

  // SCK only moves on a timer tick, a byte load or a burst preset
  AST_SCK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i && !preset_i) |=> $stable(sck_o)) else $error("sck moved"); // R5

  // every tick flips the serial clock
  AST_SCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && !preset_i) |=> (sck_o != $past(sck_o))) else $error("sck stuck"); // R2

endmodule

// File: rtl/spi_fill_master.sv
module spi_fill_master
  import spi_fill_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [DATA_W-1:0] cfg_fill_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  output logic              started_o,
  output logic              end_o,
  output logic              busy_o,
  output logic              tx_rd_o,
  output logic [LEN_W-1:0]  tx_idx_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              rx_wr_o,
  output logic [LEN_W-1:0]  rx_idx_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [LEN_W-1:0]  rx_cnt_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  // configuration register
  logic [1:0]        cfg_mode_q;
  logic [DIV_W-1:0]  cfg_div_q;
  logic [DATA_W-1:0] cfg_fill_q;
  clk_mode_t         cfg_m;

  // burst state
  xfer_state_e       st_q, st_d;
  logic [LEN_W-1:0]  tx_len_q, rx_len_q, tot_q, tot_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  rx_cnt_q, rx_cnt_d;
  logic              pend_q, pend_d;
  logic              started_q, started_d;
  logic              end_q, end_d;
  logic              latch_en;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] fill_q;
  clk_mode_t         mode_q;

  // datapath links
  logic              tick;
  logic              last_edge;
  logic              byte_load;
  logic [DATA_W-1:0] load_data;
  logic              eng_sck, eng_mosi;
  logic [DATA_W-1:0] rx_byte;

  assign cfg_m = decode_mode(cfg_mode_q);
  assign tot_d = (tx_len_i > rx_len_i) ? tx_len_i : rx_len_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode_q <= '0;
      cfg_div_q  <= '0;
      cfg_fill_q <= '0;
    end else if (cfg_we_i) begin
      cfg_mode_q <= cfg_mode_i;
      cfg_div_q  <= cfg_div_i;
      cfg_fill_q <= cfg_fill_i;
    end
  end

  // next-state logic of the burst sequencer
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    pend_d    = pend_q;
    rx_cnt_d  = rx_cnt_q;
    started_d = 1'b0;
    end_d     = 1'b0;
    latch_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d      = ST_LOAD;
          idx_d     = '0;
          pend_d    = 1'b0;
          rx_cnt_d  = '0;
          started_d = 1'b1;
          latch_en  = 1'b1;
        end
      end
      ST_LOAD: begin
        if (pend_q) begin
          rx_cnt_d = rx_cnt_q + 1'b1;
        end
        pend_d = 1'b0;
        if (idx_q == tot_q) begin
          st_d  = ST_IDLE;
          end_d = 1'b1;
        end else begin
          st_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (last_edge) begin
          st_d   = ST_LOAD;
          idx_d  = idx_q + 1'b1;
          pend_d = (idx_q < rx_len_q);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      pend_q    <= 1'b0;
      rx_cnt_q  <= '0;
      started_q <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      idx_q     <= idx_d;
      pend_q    <= pend_d;
      rx_cnt_q  <= rx_cnt_d;
      started_q <= started_d;
      end_q     <= end_d;
    end
  end

  // per-burst settings, captured at the start strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_len_q <= '0;
      rx_len_q <= '0;
      tot_q    <= '0;
      div_q    <= '0;
      fill_q   <= '0;
      mode_q   <= '0;
    end else if (latch_en) begin
      tx_len_q <= tx_len_i;
      rx_len_q <= rx_len_i;
      tot_q    <= tot_d;
      div_q    <= cfg_div_q;
      fill_q   <= cfg_fill_q;
      mode_q   <= cfg_m;
    end
  end

  assign byte_load = (st_q == ST_LOAD) && (idx_q != tot_q);
  assign tx_rd_o   = byte_load && (idx_q < tx_len_q);
  assign tx_idx_o  = idx_q;
  assign load_data = tx_rd_o ? tx_data_i : fill_q;

  spi_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == ST_SHIFT),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_bit_engine #(.DATA_W(DATA_W)) engine_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .preset_i     (latch_en),
    .preset_lvl_i (cfg_m.cpol),
    .load_i       (byte_load),
    .load_data_i  (load_data),
    .cpol_i       (mode_q.cpol),
    .cpha_i       (mode_q.cpha),
    .tick_i       (tick),
    .miso_i       (miso_i),
    .sck_o        (eng_sck),
    .mosi_o       (eng_mosi),
    .rx_byte_o    (rx_byte),
    .last_edge_o  (last_edge)
  );

  assign busy_o    = (st_q != ST_IDLE);
  assign started_o = started_q;
  assign end_o     = end_q;
  assign rx_wr_o   = (st_q == ST_LOAD) && pend_q;
  assign rx_idx_o  = rx_cnt_q;
  assign rx_data_o = rx_byte;
  assign rx_cnt_o  = rx_cnt_q;
  assign sck_o     = busy_o ? eng_sck  : cfg_m.cpol;
  assign mosi_o    = busy_o ? eng_mosi : cfg_m.cpol;

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !started_o) else $error("start while busy"); // R1

  AST_STARTED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    started_o |-> busy_o) else $error("started without busy"); // R1

  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o) else $error("end pulse too long"); // R2

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !busy_o) else $error("end while busy"); // R2

  AST_TX_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd_o |-> (tx_idx_o < tx_len_q)) else $error("tx read beyond count"); // R6

  AST_RX_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_o |-> (rx_idx_o < rx_len_q)) else $error("rx write beyond count"); // R8

  AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o) && $stable(cfg_mode_q)) |-> $stable(sck_o)) else $error("idle sck moved"); // R4

endmodule

// File: tb/spi_fill_master_tb_top.sv
`timescale 1ns/1ps
module spi_fill_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_mode_i = '0;
  logic [7:0] cfg_div_i = '0;
  logic [7:0] cfg_fill_i = '0;
  logic       start_i = 1'b0;
  logic [7:0] tx_len_i = '0;
  logic [7:0] rx_len_i = '0;
  logic       miso_i = 1'b0;
  logic       started_o, end_o, busy_o, tx_rd_o, rx_wr_o, sck_o, mosi_o;
  logic [7:0] tx_idx_o, tx_data_i, rx_idx_o, rx_data_o, rx_cnt_o;

  logic [7:0] txmem [256];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_fill_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_div_i(cfg_div_i), .cfg_fill_i(cfg_fill_i), .start_i(start_i),
    .tx_len_i(tx_len_i), .rx_len_i(rx_len_i), .started_o(started_o),
    .end_o(end_o), .busy_o(busy_o), .tx_rd_o(tx_rd_o), .tx_idx_o(tx_idx_o),
    .tx_data_i(tx_data_i), .rx_wr_o(rx_wr_o), .rx_idx_o(rx_idx_o),
    .rx_data_o(rx_data_o), .rx_cnt_o(rx_cnt_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  assign tx_data_i = txmem[tx_idx_o];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench copy of the configuration register
  logic [1:0] c_mode;
  logic [7:0] c_div, c_fill;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mode <= '0; c_div <= '0; c_fill <= '0;
    end else if (cfg_we_i) begin
      c_mode <= cfg_mode_i; c_div <= cfg_div_i; c_fill <= cfg_fill_i;
    end
  end

  // pseudo-random MISO stream
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso_i <= lfsr[0];
  end

  // expected outputs for the current cycle
  logic exp_started = 0, exp_end = 0, exp_busy = 0, exp_sck = 0, exp_mosi = 0;
  logic exp_txrd = 0, exp_rxwr = 0;
  int   exp_txidx = 0, exp_rxidx = 0, exp_rxdata = 0, exp_rxcnt = 0;

  // behavioural reference model
  initial begin : model
    int tl, rl, tot, dv, b, rxcount;
    logic cp, ph, pend, m_sck, m_mosi;
    logic [7:0] d, rxb, lastb, fill;
    rxb = '0;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (start_i) begin
        tl = tx_len_i; rl = rx_len_i; tot = (tl > rl) ? tl : rl;
        dv = c_div; cp = c_mode[1]; ph = c_mode[0]; fill = c_fill;
        b = 0; rxcount = 0; pend = 0; lastb = '0; m_sck = cp; m_mosi = cp;
        #1;
        exp_started = 1; exp_end = 0; exp_busy = 1; exp_sck = cp; exp_mosi = cp;
        forever begin
          exp_txrd = (b < tot) && (b < tl); exp_txidx = b;
          exp_rxwr = pend; exp_rxidx = rxcount; exp_rxdata = lastb; exp_rxcnt = rxcount;
          @(posedge clk);
          if (pend) rxcount++;
          if (b == tot) begin
            #1;
            exp_started = 0; exp_end = 1; exp_busy = 0; exp_txrd = 0; exp_rxwr = 0;
            exp_rxcnt = rxcount; exp_sck = c_mode[1]; exp_mosi = c_mode[1];
            break;
          end
          d = (b < tl) ? txmem[b] : fill;
          #1;
          exp_started = 0; exp_txrd = 0; exp_rxwr = 0; exp_rxcnt = rxcount;
          if (!ph) m_mosi = d[7];
          exp_mosi = m_mosi; exp_sck = m_sck;
          for (int e = 0; e < 16; e++) begin
            repeat (dv) @(posedge clk);
            @(posedge clk);
            if ((ph && (e % 2 == 1)) || (!ph && (e % 2 == 0))) rxb = {rxb[6:0], miso_i};
            #1;
            m_sck = ~m_sck;
            if (!ph && (e % 2 == 1) && e < 15) m_mosi = d[7 - (e + 1) / 2];
            if (ph && (e % 2 == 0)) m_mosi = d[7 - e / 2];
            exp_sck = m_sck; exp_mosi = m_mosi;
          end
          pend = (b < rl); lastb = rxb; b++;
        end
      end else begin
        #1;
        exp_started = 0; exp_end = 0; exp_busy = 0; exp_txrd = 0; exp_rxwr = 0;
        exp_sck = c_mode[1]; exp_mosi = c_mode[1];
      end
    end
  end

  // per-burst observation counters, cleared by the run task
  int edge_cnt, busy_cyc, end_cnt, start_cnt, txrd_cnt, rxwr_cnt, ones_cnt;
  logic last_sck = 0;

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R1", "started", started_o, exp_started);
      chk("R2", "end", end_o, exp_end);
      chk("R2", "busy", busy_o, exp_busy);
      chk(exp_busy ? "R3" : "R4", "sck", sck_o, exp_sck);
      chk(exp_busy ? "R3" : "R4", "mosi", mosi_o, exp_mosi);
      chk("R6", "tx_rd", tx_rd_o, exp_txrd);
      if (exp_txrd) chk("R6", "tx_idx", tx_idx_o, exp_txidx);
      chk("R8", "rx_wr", rx_wr_o, exp_rxwr);
      if (exp_rxwr) begin
        chk("R8", "rx_idx", rx_idx_o, exp_rxidx);
        chk("R3", "rx_data", rx_data_o, exp_rxdata);
      end
      chk("R8", "rx_cnt", rx_cnt_o, exp_rxcnt);
      if (busy_o && sck_o !== last_sck) edge_cnt++;
      if (busy_o) busy_cyc++;
      if (busy_o && mosi_o) ones_cnt++;
      if (end_o) end_cnt++;
      if (started_o) start_cnt++;
      if (tx_rd_o) txrd_cnt++;
      if (rx_wr_o) rxwr_cnt++;
    end
    last_sck = sck_o;
  end

  task automatic cfg(input logic [1:0] mode, input logic [7:0] div, input logic [7:0] fill);
    @(negedge clk);
    cfg_we_i = 1; cfg_mode_i = mode; cfg_div_i = div; cfg_fill_i = fill;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  // run one burst; the divider in effect is passed in for the timing check
  task automatic run(input int tl, input int rl, input int dv, input bit restart, input bit recfg);
    int tot;
    tot = (tl > rl) ? tl : rl;
    @(negedge clk);
    edge_cnt = 0; busy_cyc = 0; end_cnt = 0; start_cnt = 0;
    txrd_cnt = 0; rxwr_cnt = 0; ones_cnt = 0;
    tx_len_i = tl[7:0]; rx_len_i = rl[7:0]; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (restart) begin
      repeat (4) @(negedge clk);
      start_i = 1; tx_len_i = 8'd9; rx_len_i = 8'd9;
      @(negedge clk);
      start_i = 0;
    end
    if (recfg) cfg(2'b11, 8'd5, 8'hFF);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk("R2", "sck transitions", edge_cnt, 16 * tot);
    chk("R2", "end pulses", end_cnt, 1);
    chk("R1", "started pulses", start_cnt, 1);
    chk("R5", "busy cycles", busy_cyc, (tot + 1) + tot * 16 * (dv + 1));
    chk("R8", "stored count", rx_cnt_o, (rl < tot) ? rl : tot);
    chk("R6", "tx reads", txrd_cnt, (tl < tot) ? tl : tot);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 256; i++) txmem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    repeat (3) @(negedge clk);
    chk("R4", "reset sck", sck_o, 0);
    chk("R4", "reset mosi", mosi_o, 0);
    chk("R1", "reset busy", busy_o, 0);
    chk("R8", "reset rx_cnt", rx_cnt_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R7 R10: receive-only with the reset fill byte, mode 0, DIV 0
    run(0, 2, 0, 0, 0);
    chk("R7", "mosi high cycles with reset fill", ones_cnt, 0);
    chk("R10", "reads in receive-only burst", txrd_cnt, 0);

    // tx longer than rx: late receive bytes dropped
    cfg(2'b00, 8'd1, 8'hA5);
    run(3, 1, 1, 0, 0);

    // mode 1, fill after short transmit
    cfg(2'b01, 8'd0, 8'h3C);
    run(1, 3, 0, 0, 0);

    // mode 2, equal counts, DIV 2, idle level high
    cfg(2'b10, 8'd2, 8'h00);
    repeat (3) @(negedge clk);
    chk("R4", "idle sck at cpol 1", sck_o, 1);
    chk("R4", "idle mosi at cpol 1", mosi_o, 1);
    run(2, 2, 2, 0, 0);

    // R10: mode 3 write-only
    cfg(2'b11, 8'd0, 8'h81);
    run(2, 0, 0, 0, 0);
    chk("R10", "writes in write-only burst", rxwr_cnt, 0);

    // R9: empty burst
    run(0, 0, 0, 0, 0);
    chk("R9", "sck transitions in empty burst", edge_cnt, 0);
    chk("R9", "end pulses in empty burst", end_cnt, 1);

    // R1 R5: start strobe and config write during a burst, mode 0 DIV 1
    cfg(2'b00, 8'd1, 8'h5A);
    run(2, 3, 1, 1, 1);

    // R5: new settings apply to the following burst (mode 3, DIV 5)
    run(1, 1, 5, 0, 0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule